// File: doc/BRIEF.md
# Transmit Checksum Insertion Engine

This block sits in a transmit path between a packet source and a MAC. It takes a frame in as a byte stream, with a small set of sideband words that travel alongside the first byte. It stores the whole frame, and it can compute a 16-bit ones-complement checksum over the tail of the frame. The tail runs from a start offset to the last byte. The block adds a per-frame seed, folds and inverts the result, and places it big-endian at a per-frame write offset inside the stored frame. Only then does it stream the frame out. Store-and-forward is needed because the checksum field usually sits ahead of the bytes it covers.

The block also applies frame gating. A frame is consumed and dropped when transmit is disabled. It is also dropped when its length falls in the tagged-size window of 1519 to 1522 bytes while both the large-frame and the tagged-frame allowances are off. A frame longer than the buffer is dropped too. Every forwarded frame raises a one-cycle sent pulse and adds its length to a 64-bit byte counter.

The mode inputs and the sideband words are sampled on the first accepted byte of each frame.

Top module: `txcsum_engine`

## Requirements
- R1: With `csum_req` low, a forwarded frame leaves byte-for-byte as it entered, and `out_last` marks its final byte only.
- R2: With `csum_req` high, the bytes from index `csum_offsets[31:16]` to the end are summed as big-endian 16-bit words into a 32-bit sum. An odd trailing byte is padded with a zero low byte. `csum_seed` is added, the carries are folded back until 16 bits remain, and the result is inverted. The high byte is placed at index `csum_offsets[15:0]` and the low byte at the next index. A start offset at or beyond the length sums nothing but the seed.
- R3: When the write offset plus 1 is not below the frame length, the frame is forwarded unmodified.
- R4: A frame whose first byte arrives while `tx_enable` is low is fully consumed and produces no output.
- R5: With `allow_jumbo` and `allow_vlan` both low, frames of 1519 to 1522 bytes are dropped. Lengths of 1518 and 1523 are forwarded.
- R6: With either `allow_jumbo` or `allow_vlan` high, frames of 1519 to 1522 bytes are forwarded.
- R7: A frame longer than `BUF_DEPTH` bytes (2048 by default) is consumed and dropped. A frame of exactly `BUF_DEPTH` bytes is forwarded.
- R8: `in_ready` is low from the last input byte of a forwarded frame until that frame has left; in particular never while `out_valid` is high.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold.
- R10: `frame_sent` pulses for one cycle, the cycle after the final output byte is accepted, and `tx_bytes` grows by the frame length at that point. Dropped frames change neither.
- R11: After reset `out_valid` and `frame_sent` are low, `tx_bytes` is zero and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Transmit enable, sampled at first byte |
| allow_jumbo | input | 1 | Large-frame allowance, sampled at first byte |
| allow_vlan | input | 1 | Tagged-frame allowance, sampled at first byte |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final input byte of a frame |
| csum_req | input | 1 | Checksum insertion request (control word bit 0) |
| csum_offsets | input | 32 | [31:16] start offset, [15:0] write offset |
| csum_seed | input | 16 | Partial sum added before folding |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Marks the final output byte |
| frame_sent | output | 1 | One-cycle pulse per forwarded frame |
| tx_bytes | output | 64 | Total forwarded bytes |

## Verification
The hardest conditions to reach from the ports are the boundaries around insertion and gating. One is a write offset that puts the checksum in the last two bytes, next to one that is a single byte too far. Others are a start offset past the end of the frame, odd tails, and lengths just inside and just outside the tagged-size window and the buffer limit. Directed frames cover each of these edges. Random frames with random offsets, seeds and modes add the general mix. Random `out_ready` gaps and input bubbles run throughout, so output stalls meet every frame length. A monitor checks output hold and input stall on every cycle.

// File: rtl/txcsum_pkg.sv
package txcsum_pkg;

  typedef enum logic [2:0] {
    ST_FILL,
    ST_FOLD,
    ST_PUT_HI,
    ST_PUT_LO,
    ST_EMIT
  } txc_state_e;

  // Add the upper half back into the lower half twice; a 32-bit sum
  // cannot carry out after the second addition.
  function automatic logic [15:0] ones_fold(input logic [31:0] s);
    logic [16:0] a;
    logic [16:0] b;
    a = {1'b0, s[15:0]} + {1'b0, s[31:16]};
    b = {1'b0, a[15:0]} + {16'b0, a[16]};
    return b[15:0];
  endfunction

endpackage

// File: rtl/txcsum_frame_ram.sv
module txcsum_frame_ram #(
  parameter int DEPTH = 2048,
  parameter int AW    = 11,
  parameter int W     = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // Output register with enable: holds its value while the read is idle,
  // which is what lets it serve directly as the stream output stage.
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/txcsum_accum.sv
module txcsum_accum #(
  parameter int IDX_W = 12,
  parameter int SUM_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             add_en,
  input  logic             restart,
  input  logic [7:0]       byte_in,
  input  logic [IDX_W-1:0] idx,
  input  logic [15:0]      start,
  output logic [SUM_W-1:0] sum
);

  logic             in_range;
  logic             low_half;
  logic [SUM_W-1:0] term;

  always_comb begin
    in_range = 32'(idx) >= 32'(start);
    // parity of (idx - start) picks the half of the 16-bit word
    low_half = idx[0] ^ start[0];
    if (!in_range)     term = '0;
    else if (low_half) term = SUM_W'({byte_in});
    else               term = SUM_W'({byte_in, 8'h00});
  end

  always_ff @(posedge clk) begin
    if (rst)         sum <= '0;
    else if (add_en) sum <= (restart ? '0 : sum) + term;
  end

endmodule

// File: rtl/txcsum_stats.sv
module txcsum_stats #(
  parameter int LW    = 12,
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sent_evt,
  input  logic [LW-1:0]    frame_len,
  output logic             frame_sent,
  output logic [CNT_W-1:0] tx_bytes
);

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_sent <= 1'b0;
      tx_bytes   <= '0;
    end else begin
      frame_sent <= sent_evt;
      if (sent_evt) tx_bytes <= tx_bytes + CNT_W'(frame_len);
    end
  end

endmodule

// File: rtl/txcsum_engine.sv
module txcsum_engine
  import txcsum_pkg::*;
#(
  parameter int BUF_DEPTH = 2048,
  parameter int CNT_W     = 64,
  parameter int GATE_LO   = 1519,
  parameter int GATE_HI   = 1522
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_enable,
  input  logic             allow_jumbo,
  input  logic             allow_vlan,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_last,
  input  logic             csum_req,
  input  logic [31:0]      csum_offsets,
  input  logic [15:0]      csum_seed,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic             frame_sent,
  output logic [CNT_W-1:0] tx_bytes
);

  localparam int AW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
  localparam int LW = $clog2(BUF_DEPTH + 1);
  localparam logic [LW-1:0] FULL_CNT = LW'(BUF_DEPTH);

  txc_state_e state_q;
  logic [LW-1:0] cnt_q, len_q, rd_ptr_q;
  logic          started_q, ovf_q;
  logic          en_q, jumbo_q, vlan_q, creq_q;
  logic [15:0]   start_q, woff_q, seed_q, csum_q;
  logic          out_valid_q, out_last_q;

  // fill-side decode
  logic          accept, first, full;
  logic          eff_en, eff_jumbo, eff_vlan, eff_ovf;
  logic [15:0]   eff_start;
  logic [LW-1:0] len_final;
  logic          size_gated, drop_now;
  logic [31:0]   sum;

  // emit-side decode
  logic          fits_insert, adv, more, rd_en;

  // RAM port mux
  logic          ram_we;
  logic [AW-1:0] ram_waddr;
  logic [7:0]    ram_wdata;

  assign in_ready  = (state_q == ST_FILL);
  assign out_valid = out_valid_q;
  assign out_last  = out_last_q;

  always_comb begin
    accept     = in_valid && in_ready;
    first      = !started_q;
    full       = (cnt_q == FULL_CNT);
    eff_en     = first ? tx_enable   : en_q;
    eff_jumbo  = first ? allow_jumbo : jumbo_q;
    eff_vlan   = first ? allow_vlan  : vlan_q;
    eff_start  = first ? csum_offsets[31:16] : start_q;
    eff_ovf    = ovf_q || full;
    len_final  = full ? cnt_q : cnt_q + 1'b1;
    size_gated = !eff_jumbo && !eff_vlan &&
                 (32'(len_final) >= 32'(GATE_LO)) &&
                 (32'(len_final) <= 32'(GATE_HI));
    drop_now   = !eff_en || eff_ovf || size_gated;

    fits_insert = creq_q && ((32'(woff_q) + 32'd1) < 32'(len_q));
    adv         = !out_valid_q || out_ready;
    more        = rd_ptr_q < len_q;
    rd_en       = (state_q == ST_EMIT) && adv && more;

    ram_we    = 1'b0;
    ram_waddr = cnt_q[AW-1:0];
    ram_wdata = in_data;
    unique case (state_q)
      ST_FILL:   ram_we = accept && !full;
      ST_PUT_HI: begin
        ram_we    = 1'b1;
        ram_waddr = woff_q[AW-1:0];
        ram_wdata = csum_q[15:8];
      end
      ST_PUT_LO: begin
        ram_we    = 1'b1;
        ram_waddr = woff_q[AW-1:0] + AW'(1);
        ram_wdata = csum_q[7:0];
      end
      default: ram_we = 1'b0;
    endcase
  end

  txcsum_frame_ram #(
    .DEPTH (BUF_DEPTH),
    .AW    (AW),
    .W     (8)
  ) u_ram (
    .clk     (clk),
    .wr_en   (ram_we),
    .wr_addr (ram_waddr),
    .wr_data (ram_wdata),
    .rd_en   (rd_en),
    .rd_addr (rd_ptr_q[AW-1:0]),
    .rd_data (out_data)
  );

  txcsum_accum #(
    .IDX_W (LW),
    .SUM_W (32)
  ) u_accum (
    .clk     (clk),
    .rst     (rst),
    .add_en  (accept && !full),
    .restart (first),
    .byte_in (in_data),
    .idx     (cnt_q),
    .start   (eff_start),
    .sum     (sum)
  );

  txcsum_stats #(
    .LW    (LW),
    .CNT_W (CNT_W)
  ) u_stats (
    .clk        (clk),
    .rst        (rst),
    .sent_evt   (out_valid_q && out_ready && out_last_q),
    .frame_len  (len_q),
    .frame_sent (frame_sent),
    .tx_bytes   (tx_bytes)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_FILL;
      cnt_q       <= '0;
      len_q       <= '0;
      rd_ptr_q    <= '0;
      started_q   <= 1'b0;
      ovf_q       <= 1'b0;
      en_q        <= 1'b0;
      jumbo_q     <= 1'b0;
      vlan_q      <= 1'b0;
      creq_q      <= 1'b0;
      start_q     <= '0;
      woff_q      <= '0;
      seed_q      <= '0;
      csum_q      <= '0;
      out_valid_q <= 1'b0;
      out_last_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_FILL: begin
          if (accept) begin
            if (first) begin
              started_q <= 1'b1;
              en_q      <= tx_enable;
              jumbo_q   <= allow_jumbo;
              vlan_q    <= allow_vlan;
              creq_q    <= csum_req;
              start_q   <= csum_offsets[31:16];
              woff_q    <= csum_offsets[15:0];
              seed_q    <= csum_seed;
            end
            if (full) ovf_q <= 1'b1;
            else      cnt_q <= cnt_q + 1'b1;
            if (in_last) begin
              cnt_q     <= '0;
              started_q <= 1'b0;
              ovf_q     <= 1'b0;
              if (!drop_now) begin
                len_q   <= len_final;
                state_q <= ST_FOLD;
              end
            end
          end
        end
        ST_FOLD: begin
          csum_q  <= ~ones_fold(sum + 32'(seed_q));
          state_q <= fits_insert ? ST_PUT_HI : ST_EMIT;
        end
        ST_PUT_HI: state_q <= ST_PUT_LO;
        ST_PUT_LO: state_q <= ST_EMIT;
        ST_EMIT: begin
          if (adv) begin
            if (more) begin
              out_valid_q <= 1'b1;
              out_last_q  <= (rd_ptr_q == len_q - 1'b1);
              rd_ptr_q    <= rd_ptr_q + 1'b1;
            end else begin
              out_valid_q <= 1'b0;
              out_last_q  <= 1'b0;
              rd_ptr_q    <= '0;
              state_q     <= ST_FILL;
            end
          end
        end
        default: state_q <= ST_FILL;
      endcase
    end
  end

endmodule

// File: rtl/txcsum_engine_chk.sv
module txcsum_engine_chk #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             out_last,
  input logic             frame_sent,
  input logic [CNT_W-1:0] tx_bytes
);

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  a_r8_no_input_while_emitting: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  a_r10_pulse_follows_last: assert property (@(posedge clk) disable iff (rst)
    frame_sent |-> $past(out_valid && out_ready && out_last));

  a_r10_count_only_on_pulse: assert property (@(posedge clk) disable iff (rst)
    !frame_sent |-> $stable(tx_bytes));

  a_r11_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !out_valid && in_ready);

endmodule

bind txcsum_engine txcsum_engine_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .out_last   (out_last),
  .frame_sent (frame_sent),
  .tx_bytes   (tx_bytes)
);

// File: tb/txcsum_engine_bench.sv
module txcsum_engine_bench;

  localparam int DEPTH = 2048;
  localparam int MAXF  = 2200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_enable = 1'b1, allow_jumbo = 1'b0, allow_vlan = 1'b0;
  logic        in_valid = 1'b0, in_last = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        csum_req = 1'b0;
  logic [31:0] csum_offsets = '0;
  logic [15:0] csum_seed = '0;
  logic        out_valid, out_last;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        frame_sent;
  logic [63:0] tx_bytes;

  always #4 clk = ~clk;

  txcsum_engine u_txcsum_engine (
    .clk(clk), .rst(rst), .tx_enable(tx_enable), .allow_jumbo(allow_jumbo),
    .allow_vlan(allow_vlan), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .csum_req(csum_req),
    .csum_offsets(csum_offsets), .csum_seed(csum_seed),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .frame_sent(frame_sent), .tx_bytes(tx_bytes)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0] frm  [MAXF];
  logic [7:0] expf [MAXF];
  bit         exp_drop;
  logic [7:0] rxq[$];
  int         last_cnt = 0;
  int         last_pos = -1;
  bit         rx_done = 0;
  int         pulses = 0;
  longint unsigned model_bytes = 0;
  int         ready_pct = 70;

  bit         hold_pend = 0;
  logic [7:0] hold_data;
  logic       hold_last;

  // Output monitor: checks hold (R9) and input stall (R8), draws out_ready,
  // records the bytes accepted at the coming edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (hold_pend) begin
        checks++;
        if (!(out_valid && out_data == hold_data && out_last == hold_last)) begin
          errors++;
          $display("FAIL R9 stall hold: actual v=%0b d=%02h l=%0b expected v=1 d=%02h l=%0b",
                   out_valid, out_data, out_last, hold_data, hold_last);
        end
      end
      if (frame_sent) pulses++;
      if (out_valid) begin
        checks++;
        if (in_ready) begin
          errors++;
          $display("FAIL R8 in_ready during output: actual 1 expected 0");
        end
      end
      out_ready = ($urandom_range(0, 99) < ready_pct);
      if (out_valid && out_ready) begin
        rxq.push_back(out_data);
        if (out_last) begin
          last_cnt++;
          last_pos = rxq.size() - 1;
          rx_done  = 1;
        end
      end
      hold_pend = out_valid && !out_ready;
      hold_data = out_data;
      hold_last = out_last;
    end
  end

  task automatic fill_rand(input int len);
    for (int i = 0; i < len; i++) frm[i] = 8'($urandom);
  endtask

  task automatic build_exp(input int len, input bit en, input bit jmb, input bit vln,
                           input bit creq, input int st, input int wo, input int seed);
    longint s;
    logic [15:0] c;
    exp_drop = !en || (len > DEPTH) || (!jmb && !vln && len >= 1519 && len <= 1522);
    for (int i = 0; i < len; i++) expf[i] = frm[i];
    if (creq && (wo + 1 < len)) begin
      s = 0;
      for (int i = st; i < len; i++)
        s += (((i - st) % 2) == 0) ? longint'(frm[i]) * 256 : longint'(frm[i]);
      s += seed;
      while ((s >> 16) != 0) s = (s & 64'hffff) + (s >> 16);
      c = ~s[15:0];
      expf[wo]     = c[15:8];
      expf[wo + 1] = c[7:0];
    end
  endtask

  task automatic send_frame(input int len);
    bit acc;
    for (int i = 0; i < len; i++) begin
      if ($urandom_range(0, 9) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = frm[i];
      in_last  = (i == len - 1);
      do begin
        acc = in_ready;
        @(negedge clk);
      end while (!acc);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic run_frame(input int len, input bit en, input bit jmb, input bit vln,
                           input bit creq, input int st, input int wo, input int seed,
                           input string tag);
    int p0;
    longint unsigned b0;
    int bad;
    tx_enable    = en;
    allow_jumbo  = jmb;
    allow_vlan   = vln;
    csum_req     = creq;
    csum_offsets = {16'(st), 16'(wo)};
    csum_seed    = 16'(seed);
    build_exp(len, en, jmb, vln, creq, st, wo, seed);
    rxq.delete();
    last_cnt = 0;
    last_pos = -1;
    rx_done  = 0;
    p0 = pulses;
    b0 = model_bytes;
    send_frame(len);
    if (!exp_drop) begin
      for (int k = 0; k < 8000 && !rx_done; k++) @(negedge clk);
      repeat (2) @(negedge clk);
      model_bytes += longint'(len);
      checks++;
      bad = -1;
      if (rxq.size() == len) begin
        for (int i = 0; i < len; i++)
          if (bad < 0 && rxq[i] !== expf[i]) bad = i;
      end
      if (rxq.size() != len) begin
        errors++;
        $display("FAIL %s length: actual %0d expected %0d", tag, rxq.size(), len);
      end else if (bad >= 0) begin
        errors++;
        $display("FAIL %s byte %0d: actual %02h expected %02h", tag, bad, rxq[bad], expf[bad]);
      end
      checks++;  // R1 end marker
      if (last_cnt != 1 || last_pos != len - 1) begin
        errors++;
        $display("FAIL R1 last marker (%s): actual pos %0d count %0d expected pos %0d count 1",
                 tag, last_pos, last_cnt, len - 1);
      end
    end else begin
      repeat (30) @(negedge clk);
      checks++;
      if (rxq.size() != 0) begin
        errors++;
        $display("FAIL %s dropped frame output: actual %0d bytes expected 0", tag, rxq.size());
      end
    end
    checks++;  // R10 pulse and byte count
    if (pulses - p0 != (exp_drop ? 0 : 1) || tx_bytes != model_bytes) begin
      errors++;
      $display("FAIL R10 (%s): actual pulses %0d bytes %0d expected pulses %0d bytes %0d",
               tag, pulses - p0, tx_bytes, exp_drop ? 0 : 1, model_bytes);
    end
  endtask

  initial begin
    int len, st, wo;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1 || tx_bytes !== 64'd0 || frame_sent !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset state: actual v=%0b r=%0b b=%0d s=%0b expected v=0 r=1 b=0 s=0",
               out_valid, in_ready, tx_bytes, frame_sent);
    end

    // R1 plain forwarding
    fill_rand(60);  run_frame(60, 1, 0, 0, 0, 14, 20, 16'h1111, "R1");
    fill_rand(1);   run_frame(1, 1, 0, 0, 0, 0, 0, 0, "R1");
    // R2 checksum: even length, odd length, start past end
    fill_rand(64);  run_frame(64, 1, 0, 0, 1, 14, 24, 16'hbeef, "R2");
    fill_rand(71);  run_frame(71, 1, 0, 0, 1, 34, 40, 16'h0000, "R2");
    fill_rand(40);  run_frame(40, 1, 0, 0, 1, 100, 10, 16'h1234, "R2");
    for (int i = 0; i < 32; i++) frm[i] = 8'hff;
    run_frame(32, 1, 0, 0, 1, 0, 2, 16'hffff, "R2");
    // R3 insertion boundary
    fill_rand(50);  run_frame(50, 1, 0, 0, 1, 0, 48, 16'h0101, "R2");
    fill_rand(50);  run_frame(50, 1, 0, 0, 1, 0, 49, 16'h0101, "R3");
    fill_rand(50);  run_frame(50, 1, 0, 0, 1, 0, 300, 16'h0101, "R3");
    // R4 transmit disabled
    fill_rand(80);  run_frame(80, 0, 0, 0, 1, 0, 4, 0, "R4");
    fill_rand(30);  run_frame(30, 1, 0, 0, 0, 0, 0, 0, "R4");
    // R5 and R6 size gating
    fill_rand(1518); run_frame(1518, 1, 0, 0, 1, 14, 16, 16'h00aa, "R5");
    fill_rand(1519); run_frame(1519, 1, 0, 0, 0, 0, 0, 0, "R5");
    fill_rand(1522); run_frame(1522, 1, 0, 0, 0, 0, 0, 0, "R5");
    fill_rand(1523); run_frame(1523, 1, 0, 0, 0, 0, 0, 0, "R5");
    fill_rand(1520); run_frame(1520, 1, 0, 1, 0, 0, 0, 0, "R6");
    fill_rand(1519); run_frame(1519, 1, 1, 0, 1, 20, 1517, 16'h5a5a, "R6");
    // R7 buffer limit
    fill_rand(2048); run_frame(2048, 1, 0, 0, 1, 0, 2046, 16'h0f0f, "R7");
    fill_rand(2049); run_frame(2049, 1, 1, 0, 0, 0, 0, 0, "R7");

    // random mix
    for (int n = 0; n < 30; n++) begin
      len = $urandom_range(1, 200);
      st  = $urandom_range(0, len + 3);
      wo  = $urandom_range(0, len + 1);
      fill_rand(len);
      run_frame(len, ($urandom_range(0, 5) != 0), 1'($urandom), 1'($urandom),
                1'($urandom), st, wo, int'($urandom_range(0, 65535)), "R2");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R10 watchdog: actual run still active expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule